// File: doc/BRIEF.md
# Programmable Regional Clock Divider

This block derives an output clock from a fast input clock. A small configuration input chooses among three kinds of behaviour. The first is a straight pass-through, called bypass. The second is a gated copy of the input, which is the divide-by-1 path. The third is a counter-based division by an integer from 2 to 8. The block is meant to feed a local clock region. The divide setting is static, and software or strap logic changes it only while clear is held.

In divide mode a small state machine walks through a high phase and a low phase. When the ratio is odd, the low phase gets the extra input cycle. The output is a flop that changes on rising edges of the input clock. Enable starts the divider and also pauses it in place. Clear is asynchronous: it forces the output low and rewinds the phase counter, so the next start begins with a full high phase.

The state machine has four states:
- `ST_IDLE` is stopped, with the output low.
- `ST_HIGH` is the high phase of a divided period.
- `ST_LOW` is the low phase of a divided period.
- `ST_PASS` is divide-by-1 running, with the output gated from the input clock.

Its transitions are:
- IDLE to HIGH on enable when the ratio is 2 to 8.
- IDLE to PASS on enable when the ratio is 1.
- HIGH to LOW when the high count is used up.
- LOW to HIGH when the low count is used up.
- Any state to IDLE on clear.
- Every state holds while enable is low.

Top module: `rgn_clk_div`

## Requirements
- R1: With `div_sel` = 0 (bypass), `clk_out` follows `clk_in` at all times, whatever the levels of `enable` and `clear`.
- R2: With `div_sel` = 1, `clk_out` is high during the high phase of `clk_in` that follows each rising edge at which `enable` is high and `clear` is low. It is low at all other times.
- R3: With a ratio N from 2 to 8, `clk_out` rises at the first rising edge of `clk_in` at which `enable` is seen high after clear. The output then repeats with a period of exactly N input cycles.
- R4: For even N, the high phase and the low phase each last N/2 input cycles.
- R5: For odd N, the high phase lasts (N-1)/2 input cycles and the low phase lasts (N+1)/2 input cycles. For example, N=3 gives 1 cycle high and 2 cycles low.
- R6: In divide mode, a rising edge that sees `enable` low leaves `clk_out` and the phase counter unchanged. When enable returns, the waveform continues from the same phase position.
- R7: Asserting `clear` drives `clk_out` low at once, without waiting for a clock edge, and rewinds the phase counter. After clear is released, the next rising edge with `enable` high starts a fresh period with a full high phase.
- R8: Any `div_sel` value from 9 to 15 behaves exactly like divide-by-8.
- R9: Out of clear, and before any edge that sees `enable` high, `clk_out` stays low in both divide-by-1 and divide modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| clear | input | 1 | Asynchronous clear, active high; stops the divider and forces the output low |
| enable | input | 1 | Start and run enable, active high; low pauses the divider |
| div_sel | input | 4 | Ratio select: 0 is bypass, 1 to 8 is the divide ratio, 9 to 15 acts as 8 |
| clk_out | output | 1 | Output clock |

## Verification
The assertions watch three things on every cycle:
- The phase counter stays inside the high and low lengths for the selected ratio.
- The stopped state always gives a low output, and the first enabled edge out of it gives a high output.
- A paused edge changes neither the output nor the counter.

Other behaviours need the bench's scenarios:
- The exact period and duty shape of each ratio, including the odd ratios' longer low phase.
- The gating of the divide-by-1 path.
- The bypass behaviour.
- The immediate drop when clear is asserted.

The bench compares sampled waveforms against a cycle model, under random enable and clear patterns as well as a directed sweep of every ratio.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    // Divider control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // stopped, output low
        ST_HIGH = 2'd1,   // high phase of a divided period
        ST_LOW  = 2'd2,   // low phase of a divided period
        ST_PASS = 2'd3    // divide-by-1 running, gated input clock
    } rcd_state_e;

endpackage

// File: rtl/rcd_cfg_decode.sv
module rcd_cfg_decode #(
    parameter int SEL_W   = 4,
    parameter int MAX_DIV = 8,
    parameter int CNT_W   = $clog2(MAX_DIV)
) (
    input  logic [SEL_W-1:0] div_sel,
    output logic             bypass,
    output logic             div1,
    output logic [CNT_W-1:0] hi_len,
    output logic [CNT_W-1:0] lo_len
);

    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(MAX_DIV);

    logic [SEL_W-1:0] ratio;

    // Ratios above the maximum fold onto the maximum
    always_comb begin
        ratio  = (div_sel > SEL_MAX) ? SEL_MAX : div_sel;
        bypass = (ratio == '0);
        div1   = (ratio == SEL_W'(1));
        // Odd ratios give the spare cycle to the low phase
        hi_len = CNT_W'(ratio >> 1);
        lo_len = CNT_W'(ratio - (ratio >> 1));
    end

endmodule

// File: rtl/rcd_fsm.sv
module rcd_fsm
    import rcd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk_in,
    input  logic             clear,
    input  logic             enable,
    input  logic             bypass,
    input  logic             div1,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output rcd_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             div_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    rcd_state_e       state_nxt;
    logic [CNT_W-1:0] cnt_nxt;

    // Next-state and counter logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (!bypass && enable) begin
                    state_nxt = div1 ? ST_PASS : ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (enable) begin
                    if (cnt == hi_len - ONE) begin
                        state_nxt = ST_LOW;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + ONE;
                    end
                end
            end
            ST_LOW: begin
                if (enable) begin
                    if (cnt == lo_len - ONE) begin
                        state_nxt = ST_HIGH;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + ONE;
                    end
                end
            end
            ST_PASS: begin
                cnt_nxt = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_in or posedge clear) begin
        if (clear) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Output register: high exactly while in the high phase
    always_ff @(posedge clk_in or posedge clear) begin
        if (clear) begin
            div_q <= 1'b0;
        end else begin
            div_q <= (state_nxt == ST_HIGH);
        end
    end

endmodule

// File: rtl/rcd_out_stage.sv
module rcd_out_stage
    import rcd_pkg::*;
(
    input  logic       clk_in,
    input  logic       clear,
    input  logic       enable,
    input  logic       bypass,
    input  logic       div1,
    input  rcd_state_e state,
    input  logic       div_q,
    output logic       clk_out
);

    logic gate_q;

    // Gate for the divide-by-1 path, updated while the input clock is low
    always_ff @(negedge clk_in or posedge clear) begin
        if (clear) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= div1 && enable &&
                      ((state == ST_IDLE) || (state == ST_PASS));
        end
    end

    always_comb begin
        if (bypass) begin
            clk_out = clk_in;
        end else if (div1) begin
            clk_out = clk_in & gate_q;
        end else begin
            clk_out = div_q;
        end
    end

endmodule

// File: rtl/rgn_clk_div.sv
module rgn_clk_div
    import rcd_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int MAX_DIV = 8
) (
    input  logic             clk_in,
    input  logic             clear,
    input  logic             enable,
    input  logic [SEL_W-1:0] div_sel,
    output logic             clk_out
);

    localparam int CNT_W = $clog2(MAX_DIV);

    logic             cfg_bypass;
    logic             cfg_div1;
    logic [CNT_W-1:0] cfg_hi;
    logic [CNT_W-1:0] cfg_lo;
    rcd_state_e       fsm_state;
    logic [CNT_W-1:0] fsm_cnt;
    logic             fsm_div_q;

    rcd_cfg_decode #(
        .SEL_W   (SEL_W),
        .MAX_DIV (MAX_DIV),
        .CNT_W   (CNT_W)
    ) u_cfg (
        .div_sel (div_sel),
        .bypass  (cfg_bypass),
        .div1    (cfg_div1),
        .hi_len  (cfg_hi),
        .lo_len  (cfg_lo)
    );

    rcd_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk_in (clk_in),
        .clear  (clear),
        .enable (enable),
        .bypass (cfg_bypass),
        .div1   (cfg_div1),
        .hi_len (cfg_hi),
        .lo_len (cfg_lo),
        .state  (fsm_state),
        .cnt    (fsm_cnt),
        .div_q  (fsm_div_q)
    );

    rcd_out_stage u_out (
        .clk_in  (clk_in),
        .clear   (clear),
        .enable  (enable),
        .bypass  (cfg_bypass),
        .div1    (cfg_div1),
        .state   (fsm_state),
        .div_q   (fsm_div_q),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/rcd_checker.sv
module rcd_checker
    import rcd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk_in,
    input logic             clear,
    input logic             enable,
    input logic             bypass,
    input logic             div1,
    input logic [CNT_W-1:0] hi_len,
    input logic [CNT_W-1:0] lo_len,
    input rcd_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic             div_q
);

    AST_BYPASS_IDLE: assert property (@(posedge clk_in) disable iff (clear)
        bypass |-> (state == ST_IDLE));                                   // R1
    AST_PASS_DIV1: assert property (@(posedge clk_in) disable iff (clear)
        (state == ST_PASS) |-> div1);                                     // R2
    AST_START_HIGH: assert property (@(posedge clk_in) disable iff (clear)
        ((state == ST_IDLE) && enable && !bypass && !div1) |=> div_q);    // R3
    AST_HIGH_BOUND: assert property (@(posedge clk_in) disable iff (clear)
        (state == ST_HIGH) |-> (cnt < hi_len));                           // R4
    AST_LOW_BOUND: assert property (@(posedge clk_in) disable iff (clear)
        (state == ST_LOW) |-> (cnt < lo_len));                            // R5
    AST_PAUSE_HOLD: assert property (@(posedge clk_in) disable iff (clear)
        (!enable && !bypass && !div1) |=> ($stable(div_q) && $stable(cnt))); // R6
    AST_IDLE_LOW: assert property (@(posedge clk_in) disable iff (clear)
        (state == ST_IDLE) |-> !div_q);                                   // R9

endmodule

bind rgn_clk_div rcd_checker #(.CNT_W(CNT_W)) u_rcd_chk (
    .clk_in (clk_in),
    .clear  (clear),
    .enable (enable),
    .bypass (cfg_bypass),
    .div1   (cfg_div1),
    .hi_len (cfg_hi),
    .lo_len (cfg_lo),
    .state  (fsm_state),
    .cnt    (fsm_cnt),
    .div_q  (fsm_div_q)
);

// File: tb/rgn_clk_div_bench.sv
`timescale 1ns/1ps
module rgn_clk_div_bench;

    logic       clk = 1'b0;
    logic       clear;
    logic       enable;
    logic [3:0] div_sel;
    logic       clk_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Cycle model of the divide path
    bit m_run = 1'b0;
    int m_ph  = 0;

    always #4 clk = ~clk;

    rgn_clk_div u_rgn_clk_div (
        .clk_in  (clk),
        .clear   (clear),
        .enable  (enable),
        .div_sel (div_sel),
        .clk_out (clk_out)
    );

    function automatic int eff_n(input logic [3:0] s);
        return (s > 4'd8) ? 8 : int'(s);
    endfunction

    function automatic int hi_of(input int n);
        return n / 2;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    // One input cycle: advance the model at the edge, sample 1 ns later,
    // return 2 ns after the edge so the caller may change inputs.
    task automatic cycle(input string req);
        logic exp;
        int   n;
        @(posedge clk);
        n = eff_n(div_sel);
        if (clear) begin
            m_run = 1'b0;
            m_ph  = 0;
        end else if (enable && n >= 2) begin
            if (!m_run) begin
                m_run = 1'b1;
                m_ph  = 0;
            end else begin
                m_ph = (m_ph + 1) % n;
            end
        end
        if (n == 0)      exp = 1'b1;
        else if (n == 1) exp = enable && !clear;
        else             exp = m_run && (m_ph < hi_of(n));
        #1;
        chk(req, clk_out, exp);
        #1;
    endtask

    task automatic restart(input logic [3:0] s);
        clear   = 1'b1;
        enable  = 1'b0;
        div_sel = s;
        cycle("R7 clear hold");
        clear = 1'b0;
    endtask

    initial begin
        int seed;
        int hi_cnt;
        int lo_cnt;
        seed    = $urandom(32'd1234);
        clear   = 1'b1;
        enable  = 1'b0;
        div_sel = 4'd3;

        // Reset state
        cycle("R9 reset low");
        cycle("R9 reset low");

        // Directed sweep of every ratio with enable held high
        for (int s = 1; s <= 8; s++) begin
            restart(4'(s));
            cycle("R9 idle low before enable");
            enable = 1'b1;
            for (int k = 0; k < 3 * s + 2; k++) begin
                cycle((s % 2 == 0) ? "R4 even shape" : "R5 odd shape");
            end
        end

        // Phase counts for N=3 and N=6 (R3, R4, R5)
        for (int s = 3; s <= 6; s += 3) begin
            restart(4'(s));
            enable = 1'b1;
            hi_cnt = 0;
            lo_cnt = 0;
            for (int k = 0; k < 2 * s; k++) begin
                cycle("R3 period");
                if (clk_out) hi_cnt++;
                else         lo_cnt++;
            end
            chk("R3 first-period high count", hi_cnt == 2 * (s / 2), 1'b1);
            chk((s == 3) ? "R5 low count" : "R4 low count",
                lo_cnt == 2 * (s - s / 2), 1'b1);
        end

        // Divide-by-1 low phase must stay low (R2)
        restart(4'd1);
        enable = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cycle("R2 gated high");
            @(negedge clk);
            #1;
            chk("R2 low phase", clk_out, 1'b0);
            @(posedge clk);
            #2;
        end
        enable = 1'b0;
        cycle("R2 gated off");
        cycle("R2 gated off");

        // Bypass ignores enable and clear (R1)
        div_sel = 4'd0;
        clear   = 1'b1;
        enable  = 1'b0;
        cycle("R1 bypass high");
        @(negedge clk);
        #1;
        chk("R1 bypass low", clk_out, 1'b0);
        clear  = 1'b0;
        enable = 1'b1;
        cycle("R1 bypass high");

        // Pause and resume at N=5 (R6)
        restart(4'd5);
        enable = 1'b1;
        for (int k = 0; k < 6; k++) cycle("R6 before pause");
        enable = 1'b0;
        for (int k = 0; k < 4; k++) cycle("R6 paused");
        enable = 1'b1;
        for (int k = 0; k < 10; k++) cycle("R6 resumed");

        // Clear during the high phase drops the output at once (R7)
        restart(4'd8);
        enable = 1'b1;
        cycle("R7 high before clear");
        clear = 1'b1;
        #1;
        chk("R7 async low", clk_out, 1'b0);
        #1;
        cycle("R7 held");
        clear = 1'b0;
        for (int k = 0; k < 8; k++) cycle("R7 restart full high");

        // Out-of-range select acts as 8 (R8)
        restart(4'd12);
        enable = 1'b1;
        for (int k = 0; k < 17; k++) cycle("R8 folds to 8");

        // Constrained random: ratio 1..8 or above, random enable and clear pulses
        for (int r = 0; r < 40; r++) begin
            restart(4'($urandom_range(15, 1)));
            for (int k = 0; k < 30; k++) begin
                cycle("R3 R6 R7 random");
                enable = ($urandom_range(99, 0) < 70);
                clear  = ($urandom_range(99, 0) < 5);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule